// File: doc/BRIEF.md
# Independent Watchdog Timer

This block is a watchdog that counts on its own slow clock, nominally around 40 kHz and allowed to drift between roughly 30 and 60 kHz. Its configuration is held on the bus clock side. Software talks to it through four word registers on a simple bus: a key register, a divider-setting register, a reload register and a status register. Software arms the watchdog and refreshes it by writing command keys to the key register. Once armed, the watchdog cannot be disarmed. If software does not refresh it in time, the block drives a reset pulse.

The divider and reload settings are write-protected. An unlock key must come first before either register accepts a write. An accepted value is handed to the slow clock domain through a toggle handshake. A separate busy flag for each register stays set until the slow side has taken the value. Writes to a register whose flag is set are dropped, so the value being carried never changes while it is in flight. The slow side divides its clock by 4·2^P, where P is the 3-bit divider setting. It decrements a 12-bit counter on each divided tick. The timeout is R·4·2^P slow cycles for a reload value R of 1 or more.

Top module: `lsw_watchdog`

## Requirements
- R1: After reset, the divider setting reads 0, the reload reads 0xFFF, the status reads 0 and `wdt_rst` is low.
- R2: The register address map is 0 for key, 1 for the divider setting (bits 2:0), 2 for reload (bits 11:0) and 3 for status. In status, bit 0 is divider-busy and bit 1 is reload-busy. The key address reads as 0.
- R3: Writes to the divider and reload registers take effect only while unlocked. Writing key 0x5555 unlocks. Writing any key value other than 0x5555, 0xAAAA or 0xCCCC locks again. A locked write changes neither register nor status.
- R4: An accepted divider or reload write sets its busy flag from the next bus cycle. The flag clears on its own once the slow domain holds the value. A write to that register while its flag is set is ignored.
- R5: Before key 0xCCCC has been written, `wdt_rst` never goes high, even if refresh keys are written.
- R6: While armed and not refreshed, successive rising edges of `wdt_rst` are exactly max(R,1)·4·2^P slow clock cycles apart.
- R7: Each reset pulse lasts exactly RST_LEN slow clock cycles (default 2).
- R8: Key 0xAAAA restarts both the divider and the down-counter from the reload value. Refreshing more often than the timeout keeps `wdt_rst` low. When refreshing stops, a pulse follows within one timeout.
- R9: Once armed, no key or register write stops the watchdog.
- R10: A refresh that reaches the slow domain in the same cycle as a new reload value loads the new value. A refresh wins over an expiry that falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| lclk | input | 1 | Slow independent counting clock |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address, zero when not selected |
| wdt_rst | output | 1 | Reset request pulse, slow clock domain |

## Verification
Two events can land in the same slow clock cycle: a refresh key, and the capture of a freshly written reload value. The bench provokes this by writing a new reload value and a refresh key on bus cycles only two apart, well inside one slow period. Both toggles then cross the same synchronizer depth. The bench then counts slow cycles to the next pulse and requires the count to match the new reload value plus only the crossing latency, not the old value. Interval sweeps over divider settings 0 to 2 and several reload values, including 0, are judged against the arithmetic period.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
    typedef enum logic [1:0] {
        ADDR_KEY  = 2'd0,
        ADDR_PSC  = 2'd1,
        ADDR_RLD  = 2'd2,
        ADDR_STAT = 2'd3
    } wdt_addr_e;

    // toggle request lanes from bus side to slow side
    localparam int REQ_PSC   = 0;
    localparam int REQ_RLD   = 1;
    localparam int REQ_FEED  = 2;
    localparam int REQ_START = 3;
    localparam int REQ_N     = 4;
endpackage

// File: rtl/lsw_sync.sv
module lsw_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/lsw_bus_regs.sv
module lsw_bus_regs
    import lsw_pkg::*;
#(
    parameter int                PSC_W      = 3,
    parameter int                CNT_W      = 12,
    parameter int                DATA_W     = 16,
    parameter logic [DATA_W-1:0] KEY_FEED   = 16'hAAAA,
    parameter logic [DATA_W-1:0] KEY_START  = 16'hCCCC,
    parameter logic [DATA_W-1:0] KEY_UNLOCK = 16'h5555
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        ack_sync,
    output logic [REQ_N-1:0]  req_tgl,
    output logic [PSC_W-1:0]  psc_val,
    output logic [CNT_W-1:0]  rld_val,
    output logic              unlocked,
    output logic              running,
    output logic              psc_busy,
    output logic              rld_busy
);
    typedef struct packed {
        logic             unlocked;
        logic             running;
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] rld;
        logic [REQ_N-1:0] req;
    } bus_st_t;

    bus_st_t           st_d, st_q;
    logic [1:0]        busy;
    logic [DATA_W-1:0] rd_word;
    wdt_addr_e         addr;

    always_comb begin
        st_d    = st_q;
        busy    = st_q.req[1:0] ^ ack_sync;
        addr    = wdt_addr_e'(bus_addr);
        rd_word = '0;

        if (bus_sel && bus_wr) begin
            unique case (addr)
                ADDR_KEY: begin
                    if (bus_wdata == KEY_FEED) begin
                        st_d.req[REQ_FEED] = ~st_q.req[REQ_FEED];
                    end else if (bus_wdata == KEY_START) begin
                        st_d.running        = 1'b1;
                        st_d.req[REQ_START] = ~st_q.req[REQ_START];
                    end else if (bus_wdata == KEY_UNLOCK) begin
                        st_d.unlocked = 1'b1;
                    end else begin
                        st_d.unlocked = 1'b0;
                    end
                end
                ADDR_PSC: begin
                    if (st_q.unlocked && !busy[REQ_PSC]) begin
                        st_d.psc          = bus_wdata[PSC_W-1:0];
                        st_d.req[REQ_PSC] = ~st_q.req[REQ_PSC];
                    end
                end
                ADDR_RLD: begin
                    if (st_q.unlocked && !busy[REQ_RLD]) begin
                        st_d.rld          = bus_wdata[CNT_W-1:0];
                        st_d.req[REQ_RLD] = ~st_q.req[REQ_RLD];
                    end
                end
                default: ;
            endcase
        end

        unique case (addr)
            ADDR_PSC:  rd_word[PSC_W-1:0] = st_q.psc;
            ADDR_RLD:  rd_word[CNT_W-1:0] = st_q.rld;
            ADDR_STAT: rd_word[1:0]       = busy;
            default:   rd_word            = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.rld <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = bus_sel ? rd_word : '0;
    assign req_tgl   = st_q.req;
    assign psc_val   = st_q.psc;
    assign rld_val   = st_q.rld;
    assign unlocked  = st_q.unlocked;
    assign running   = st_q.running;
    assign psc_busy  = busy[REQ_PSC];
    assign rld_busy  = busy[REQ_RLD];
endmodule

// File: rtl/lsw_core.sv
module lsw_core
    import lsw_pkg::*;
#(
    parameter int PSC_W   = 3,
    parameter int CNT_W   = 12,
    parameter int RST_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REQ_N-1:0] req_sync,
    input  logic [PSC_W-1:0] psc_in,
    input  logic [CNT_W-1:0] rld_in,
    output logic [1:0]       ack,
    output logic             run,
    output logic             wdt_rst
);
    localparam int DIV_W = 2 + (1 << PSC_W) - 1;
    localparam int RC_W  = $clog2(RST_LEN + 1);

    typedef struct packed {
        logic [REQ_N-1:0] req_prev;
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] rld;
        logic [DIV_W-1:0] pdiv;
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic [RC_W-1:0]  rcnt;
    } core_st_t;

    core_st_t         st_d, st_q;
    logic [REQ_N-1:0] edges;
    logic [DIV_W:0]   ratio_m1;
    logic             tick;
    logic             fire;

    always_comb begin
        st_d          = st_q;
        edges         = req_sync ^ st_q.req_prev;
        st_d.req_prev = req_sync;
        ratio_m1      = ((DIV_W+1)'(4) << st_q.psc) - (DIV_W+1)'(1);
        tick          = st_q.run && ({1'b0, st_q.pdiv} >= ratio_m1);
        fire          = 1'b0;

        if (edges[REQ_PSC]) st_d.psc = psc_in;
        if (edges[REQ_RLD]) st_d.rld = rld_in;

        // arm and refresh take the freshly captured reload, and win over expiry
        if (edges[REQ_START]) begin
            st_d.run  = 1'b1;
            st_d.cnt  = st_d.rld;
            st_d.pdiv = '0;
        end else if (edges[REQ_FEED] && st_q.run) begin
            st_d.cnt  = st_d.rld;
            st_d.pdiv = '0;
        end else if (tick) begin
            st_d.pdiv = '0;
            if (st_q.cnt <= CNT_W'(1)) begin
                st_d.cnt = st_d.rld;
                fire     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end else if (st_q.run) begin
            st_d.pdiv = st_q.pdiv + DIV_W'(1);
        end

        if (fire) begin
            st_d.rcnt = RC_W'(RST_LEN);
        end else if (st_q.rcnt != '0) begin
            st_d.rcnt = st_q.rcnt - RC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.rld <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack     = st_q.req_prev[1:0];
    assign run     = st_q.run;
    assign wdt_rst = (st_q.rcnt != '0);
endmodule

// File: rtl/lsw_watchdog.sv
module lsw_watchdog
    import lsw_pkg::*;
#(
    parameter int                PSC_W       = 3,
    parameter int                CNT_W       = 12,
    parameter int                DATA_W      = 16,
    parameter int                RST_LEN     = 2,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] KEY_FEED    = 16'hAAAA,
    parameter logic [DATA_W-1:0] KEY_START   = 16'hCCCC,
    parameter logic [DATA_W-1:0] KEY_UNLOCK  = 16'h5555
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lclk,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_rst
);
    logic [REQ_N-1:0] req_tgl, req_ls;
    logic [1:0]       ack_ls, ack_bus;
    logic [PSC_W-1:0] psc_val;
    logic [CNT_W-1:0] rld_val;
    logic             unlocked, running, psc_busy, rld_busy;
    logic             ls_rst_n, core_run;

    lsw_bus_regs #(
        .PSC_W(PSC_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
        .KEY_FEED(KEY_FEED), .KEY_START(KEY_START), .KEY_UNLOCK(KEY_UNLOCK)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack_sync(ack_bus), .req_tgl(req_tgl),
        .psc_val(psc_val), .rld_val(rld_val),
        .unlocked(unlocked), .running(running),
        .psc_busy(psc_busy), .rld_busy(rld_busy)
    );

    lsw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_lrst_sync (
        .clk(lclk), .rst_n(rst_n), .d(1'b1), .q(ls_rst_n)
    );

    lsw_sync #(.WIDTH(REQ_N), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk(lclk), .rst_n(rst_n), .d(req_tgl), .q(req_ls)
    );

    lsw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_ls), .q(ack_bus)
    );

    lsw_core #(.PSC_W(PSC_W), .CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_core (
        .clk(lclk), .rst_n(ls_rst_n),
        .req_sync(req_ls), .psc_in(psc_val), .rld_in(rld_val),
        .ack(ack_ls), .run(core_run), .wdt_rst(wdt_rst)
    );
endmodule

// File: rtl/lsw_watchdog_chk.sv
module lsw_watchdog_chk #(
    parameter int PSC_W   = 3,
    parameter int CNT_W   = 12,
    parameter int RST_LEN = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lclk,
    input logic             ls_rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic             unlocked,
    input logic             psc_busy,
    input logic             rld_busy,
    input logic [PSC_W-1:0] psc_val,
    input logic [CNT_W-1:0] rld_val,
    input logic             running,
    input logic             core_run,
    input logic             wdt_rst
);
    int unsigned hi_cnt;

    always_ff @(posedge lclk or negedge ls_rst_n) begin
        if (!ls_rst_n)    hi_cnt <= 0;
        else if (wdt_rst) hi_cnt <= hi_cnt + 1;
        else              hi_cnt <= 0;
    end

    assert_locked_psc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd1 && !unlocked) |=> $stable(psc_val));

    assert_locked_rld_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd2 && !unlocked) |=> $stable(rld_val));

    assert_busy_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd1 && unlocked && !psc_busy) |=> psc_busy);

    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd2 && rld_busy) |=> $stable(rld_val));

    assert_idle_quiet_R5: assert property (@(posedge lclk) disable iff (!ls_rst_n)
        !core_run |-> !wdt_rst);

    assert_pulse_len_R7: assert property (@(posedge lclk) disable iff (!ls_rst_n)
        $fell(wdt_rst) |-> (hi_cnt == RST_LEN));

    assert_run_sticky_R9: assert property (@(posedge lclk) disable iff (!ls_rst_n)
        !$fell(core_run));

    assert_arm_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(running));
endmodule

bind lsw_watchdog lsw_watchdog_chk #(
    .PSC_W(PSC_W), .CNT_W(CNT_W), .RST_LEN(RST_LEN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lclk(lclk), .ls_rst_n(ls_rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .unlocked(unlocked), .psc_busy(psc_busy), .rld_busy(rld_busy),
    .psc_val(psc_val), .rld_val(rld_val),
    .running(running), .core_run(core_run), .wdt_rst(wdt_rst)
);

// File: tb/lsw_watchdog_test.sv
module lsw_watchdog_test;
    logic        clk = 1'b0;
    logic        lclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        wdt_rst;

    int total = 0;
    int bad = 0;
    int unsigned cyc = 0;

    localparam int RST_LEN = 2;

    lsw_watchdog #(.RST_LEN(RST_LEN)) uut (
        .clk(clk), .rst_n(rst_n), .lclk(lclk),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst(wdt_rst)
    );

    always #2  clk  = ~clk;
    always #20 lclk = ~lclk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output int v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        v = int'(bus_rdata);
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        int s;
        for (int i = 0; i < 500; i++) begin
            bus_read(2'd3, s);
            if (s == 0) break;
        end
    endtask

    task automatic set_cfg(input int p, input int r);
        bus_write(2'd0, 16'h5555);
        bus_write(2'd1, 16'(p));
        wait_idle();
        bus_write(2'd2, 16'(r));
        wait_idle();
    endtask

    // slow cycles until the next rising edge of wdt_rst
    task automatic wait_rise(output int n);
        logic prev;
        prev = wdt_rst;
        n = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge lclk);
            n++;
            if (wdt_rst && !prev) return;
            prev = wdt_rst;
        end
        n = -1;
    endtask

    initial begin
        int v, n, w, seen, exp;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge lclk);

        // R1 / R2 reset values and map
        bus_read(2'd1, v); check("R1 divider reset", v, 0);
        bus_read(2'd2, v); check("R1 reload reset", v, 4095);
        bus_read(2'd3, v); check("R1 status reset", v, 0);
        bus_read(2'd0, v); check("R2 key reads zero", v, 0);
        check("R1 reset output low", int'(wdt_rst), 0);

        // R5 refresh before arming does nothing
        bus_write(2'd0, 16'hAAAA);
        seen = 0;
        repeat (200) begin @(negedge lclk); if (wdt_rst) seen = 1; end
        check("R5 no pulse before arm", seen, 0);

        // R3 locked writes dropped
        bus_write(2'd1, 16'd5);
        bus_read(2'd1, v); check("R3 locked divider", v, 0);
        bus_write(2'd2, 16'd3);
        bus_read(2'd2, v); check("R3 locked reload", v, 4095);
        bus_read(2'd3, v); check("R3 locked status", v, 0);

        // R4 busy flags and writes while busy
        bus_write(2'd0, 16'h5555);
        bus_write(2'd1, 16'd1);
        bus_read(2'd3, v); check("R4 divider busy set", v, 1);
        bus_write(2'd1, 16'd6);
        bus_read(2'd1, v); check("R4 write while busy ignored", v, 1);
        wait_idle();
        bus_read(2'd3, v); check("R4 divider busy clears", v, 0);
        bus_write(2'd2, 16'd9);
        bus_read(2'd3, v); check("R4 reload busy set", v, 2);
        wait_idle();
        bus_read(2'd2, v); check("R4 reload value", v, 9);

        // R3 other key relocks
        bus_write(2'd0, 16'h1234);
        bus_write(2'd1, 16'd2);
        bus_read(2'd1, v); check("R3 relocked", v, 1);

        // R6 / R7 arm and measure
        set_cfg(0, 3);
        bus_write(2'd0, 16'hCCCC);
        wait_rise(n);
        wait_rise(n); check("R6 period p0 r3", n, 12);
        w = 1;
        for (int i = 0; i < 50; i++) begin
            @(negedge lclk);
            if (wdt_rst) w++; else break;
        end
        check("R7 pulse width", w, RST_LEN);

        // R9 stray keys do not stop it
        bus_write(2'd0, 16'h0000);
        bus_write(2'd0, 16'h1234);
        wait_rise(n);
        wait_rise(n); check("R9 still running", n, 12);

        // R6 sweep
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < 4; k++) begin
                int r;
                r = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 3 : 6;
                set_cfg(p, r);
                wait_rise(n);
                wait_rise(n);
                exp = ((r == 0) ? 1 : r) * (4 << p);
                check($sformatf("R6 period p%0d r%0d", p, r), n, exp);
            end
        end

        // R8 refresh holds it off
        set_cfg(0, 10);
        wait_rise(n);
        bus_write(2'd0, 16'hAAAA);
        repeat (60) @(negedge clk);
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            bus_write(2'd0, 16'hAAAA);
            repeat (100) begin @(negedge clk); if (wdt_rst) seen = 1; end
        end
        check("R8 refreshed no pulse", seen, 0);
        wait_rise(n);
        check("R8 pulse after refresh stops", int'(n > 0 && n <= 40), 1);

        // R10 reload capture and refresh together
        bus_write(2'd0, 16'h5555);
        bus_write(2'd2, 16'd7);
        bus_write(2'd0, 16'hAAAA);
        wait_rise(n);
        check("R10 refresh uses new reload", int'(n >= 28 && n <= 33), 1);
        wait_rise(n);
        check("R10 period after update", n, 28);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule